// File: doc/BRIEF.md
# PAM-4 Early/Late Phase Vote Generator

This block is the digital phase-detector stage of a baud-rate clock recovery loop for four-level signalling. Each clock it accepts one deserialized word holding `N_SYM` data decisions and the `N_SYM-1` edge samples taken halfway between neighbouring symbols. For every pair of neighbouring symbols it decides whether that transition carries usable timing information. If it does, it raises an early or a late flag for that slot, following the bang-bang rule: an edge sample that agrees with the later symbol means early, and one that agrees with the earlier symbol means late.

The `mode` input selects which transitions may vote. In strict mode only transitions symmetric about zero vote. Partial mode uses a single zero comparator and keeps only the unambiguous outcome of asymmetric zero crossings. Open mode lets every zero crossing vote. Triple mode uses a bank of low, zero and high comparators. In triple mode, `sum_sel` chooses whether the comparator outcomes of an asymmetric crossing are reduced to one majority vote or kept as a summed weight. A downstream loop filter consumes the registered flag vectors and the per-slot weights.

Top module: `pam4_el_detector`

## Requirements
- R1: After reset `out_valid`, `early`, `late` and `weight` are all zero. From then on `out_valid` equals `in_valid` of the previous cycle, and the flags belong to the word presented in that cycle.
- R2: In any cycle where `out_valid` is low, `early`, `late` and `weight` are all zero.
- R3: A slot whose two symbols have the same code never raises early or late, in any mode.
- R4: Symbols use codes 00, 01, 10, 11 for levels -3, -1, +1, +3. Symbol i sits at `sym_in[2i+1:2i]`, with i=0 the earliest. Slot k covers symbols k and k+1 and uses `edge_in[3k+2:3k]` = {high(+2), zero(0), low(-2)} comparator outputs, where 1 means the signal is above that threshold. A comparator whose threshold the pair crosses votes early when its sample equals the later symbol's side and late when it equals the earlier symbol's side.
- R5: Mode 0 (strict): only the pairs 00/11 and 01/10 (either direction) vote, using the zero comparator. All other pairs give no flag.
- R6: Mode 1 (partial): zero-symmetric pairs vote as in R5. For an asymmetric zero crossing whose earlier symbol is an outer level (00 or 11), only an early outcome is kept. When the earlier symbol is an inner level, only a late outcome is kept. The suppressed outcome gives no flag.
- R7: Mode 2 (open): every pair whose symbols lie on opposite sides of zero votes with the zero comparator.
- R8: Mode 3 (triple): zero-symmetric pairs use the zero comparator. The pairs 10/11 use the high comparator, and the pairs 00/01 use the low comparator.
- R9: Mode 3, asymmetric zero crossings: the votes (+1 early, -1 late, 0 for uncrossed comparators) of all three comparators are added. A positive sum flags early and a negative sum flags late. With `sum_sel`=0 (majority) the weight is 1 for a flagged slot. With `sum_sel`=1 (summation) the weight is the absolute sum.
- R10: Early and late are never both set in a slot. A slot's weight is non-zero exactly when one of its flags is set. In modes 0 to 2 that weight is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word qualifier |
| mode | input | 2 | Transition selection: 0 strict, 1 partial, 2 open, 3 triple |
| sum_sel | input | 1 | Triple-mode combining: 0 majority, 1 summation |
| sym_in | input | 2*N_SYM | Data decisions, two bits per symbol |
| edge_in | input | 3*(N_SYM-1) | Edge comparator samples, three bits per slot |
| out_valid | output | 1 | Registered qualifier for the flag vectors |
| early | output | N_SYM-1 | Per-slot early flags |
| late | output | N_SYM-1 | Per-slot late flags |
| weight | output | 2*(N_SYM-1) | Per-slot vote magnitude, two bits per slot |

## Verification
The assertions assume that `in_valid`, `mode`, `sum_sel` and the data fields are known from the first clock after reset. Mode is sampled in the same cycle as the word, so no stability across words is assumed. The edge bits are not assumed to form a thermometer code, so the properties must hold for contradictory comparator triples as well. The stimulus therefore drives every input to a known value from time zero and changes them only on falling edges. It draws edge samples uniformly over all eight patterns, including the inconsistent ones, so the properties are exercised outside the physically expected cases.

// File: rtl/pam4_el_pkg.sv
package pam4_el_pkg;

   localparam int SYM_W  = 2;
   localparam int EDGE_W = 3;
   localparam int WT_W   = 2;

   typedef enum logic [1:0] {
      EL_STRICT  = 2'd0,
      EL_PARTIAL = 2'd1,
      EL_OPEN    = 2'd2,
      EL_TRIPLE  = 2'd3
   } el_mode_e;

   typedef struct packed {
      logic            early;
      logic            late;
      logic [WT_W-1:0] wt;
   } el_vote_t;

   // +1 when the sample sides with the later symbol, -1 with the earlier,
   // 0 when the pair lies on one side of this comparator's threshold
   function automatic logic signed [2:0] cmp_vote(input logic side_a,
                                                  input logic side_b,
                                                  input logic smp);
      if (side_a == side_b) return 3'sd0;
      return (smp == side_b) ? 3'sd1 : -3'sd1;
   endfunction

endpackage

// File: rtl/pam4_el_slot.sv
module pam4_el_slot
   import pam4_el_pkg::*;
(
   input  logic [SYM_W-1:0]  sym_a,
   input  logic [SYM_W-1:0]  sym_b,
   input  logic [EDGE_W-1:0] smp,
   input  el_mode_e          mode,
   input  logic              sum_sel,
   output el_vote_t          vote
);

   logic signed [2:0] v_lo, v_z, v_hi, net;
   logic        [2:0] mag;
   logic              zsym, hsym, lsym, zcross, asym, outer_a;

   // pair classification from the codes
   assign zsym    = ((sym_a ^ sym_b) == 2'b11);
   assign hsym    = sym_a[1] & sym_b[1] & (sym_a[0] ^ sym_b[0]);
   assign lsym    = ~sym_a[1] & ~sym_b[1] & (sym_a[0] ^ sym_b[0]);
   assign zcross  = sym_a[1] ^ sym_b[1];
   assign asym    = zcross & ~zsym;
   assign outer_a = ~(sym_a[1] ^ sym_a[0]);

   always_comb begin
      v_lo = cmp_vote(|sym_a, |sym_b, smp[0]);
      v_z  = cmp_vote(sym_a[1], sym_b[1], smp[1]);
      v_hi = cmp_vote(&sym_a, &sym_b, smp[2]);
      net  = 3'sd0;
      unique case (mode)
         EL_STRICT: begin
            if (zsym) net = v_z;
         end
         EL_PARTIAL: begin
            if (zsym)
               net = v_z;
            else if (asym)
               // outer start: crossing lands after mid-edge, only early is sure
               net = outer_a ? ((v_z > 3'sd0) ? v_z : 3'sd0)
                             : ((v_z < 3'sd0) ? v_z : 3'sd0);
         end
         EL_OPEN: begin
            net = v_z;
         end
         EL_TRIPLE: begin
            if (zsym)      net = v_z;
            else if (hsym) net = v_hi;
            else if (lsym) net = v_lo;
            else if (asym) net = v_lo + v_z + v_hi;
         end
         default: net = 3'sd0;
      endcase
      mag        = (net < 3'sd0) ? 3'(-net) : 3'(net);
      vote.early = (net > 3'sd0);
      vote.late  = (net < 3'sd0);
      vote.wt    = sum_sel ? mag[WT_W-1:0] : {1'b0, (net != 3'sd0)};
   end

endmodule

// File: rtl/pam4_el_outreg.sv
module pam4_el_outreg
   import pam4_el_pkg::*;
#(
   parameter int SLOTS = 31
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   vld_in,
   input  el_vote_t [SLOTS-1:0]   votes,
   output logic                   vld_out,
   output logic [SLOTS-1:0]       early_q,
   output logic [SLOTS-1:0]       late_q,
   output logic [WT_W*SLOTS-1:0]  wt_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_out <= 1'b0;
         early_q <= '0;
         late_q  <= '0;
         wt_q    <= '0;
      end else begin
         vld_out <= vld_in;
         for (int k = 0; k < SLOTS; k++) begin
            early_q[k]              <= vld_in & votes[k].early;
            late_q[k]               <= vld_in & votes[k].late;
            wt_q[WT_W*k +: WT_W]    <= vld_in ? votes[k].wt : '0;
         end
      end
   end

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_out |-> (early_q == '0) && (late_q == '0) && (wt_q == '0));

   for (genvar k = 0; k < SLOTS; k++) begin : g_chk
      // R10
      one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(early_q[k] && late_q[k]));
      // R10
      wt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wt_q[WT_W*k +: WT_W] != '0) == (early_q[k] || late_q[k]));
   end

endmodule

// File: rtl/pam4_el_detector.sv
module pam4_el_detector
   import pam4_el_pkg::*;
#(
   parameter int N_SYM = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic [1:0]                mode,
   input  logic                      sum_sel,
   input  logic [2*N_SYM-1:0]        sym_in,
   input  logic [3*(N_SYM-1)-1:0]    edge_in,
   output logic                      out_valid,
   output logic [N_SYM-2:0]          early,
   output logic [N_SYM-2:0]          late,
   output logic [2*(N_SYM-1)-1:0]    weight
);

   localparam int SLOTS = N_SYM - 1;

   if (N_SYM < 2) begin : g_bad_nsym
      $error("pam4_el_detector: N_SYM must be at least 2");
   end

   el_mode_e             mode_e;
   el_vote_t [SLOTS-1:0] votes;

   assign mode_e = el_mode_e'(mode);

   for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      pam4_el_slot u_slot (
         .sym_a   (sym_in[SYM_W*k +: SYM_W]),
         .sym_b   (sym_in[SYM_W*(k+1) +: SYM_W]),
         .smp     (edge_in[EDGE_W*k +: EDGE_W]),
         .mode    (mode_e),
         .sum_sel (sum_sel),
         .vote    (votes[k])
      );

      // R3
      same_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && sym_in[SYM_W*k +: SYM_W] == sym_in[SYM_W*(k+1) +: SYM_W])
         |=> !early[k] && !late[k]);
      // R5
      strict_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && mode == 2'd0 &&
          (sym_in[SYM_W*k +: SYM_W] ^ sym_in[SYM_W*(k+1) +: SYM_W]) != 2'b11)
         |=> !early[k] && !late[k]);
      // R6
      partial_outer_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && mode == 2'd1 &&
          sym_in[SYM_W*k+1] != sym_in[SYM_W*(k+1)+1] &&
          sym_in[SYM_W*k+1] == sym_in[SYM_W*k] &&
          (sym_in[SYM_W*k +: SYM_W] ^ sym_in[SYM_W*(k+1) +: SYM_W]) != 2'b11)
         |=> !late[k]);
      // R9
      majority_wt_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !sum_sel) |=> weight[WT_W*k +: WT_W] <= 2'd1);
   end

   pam4_el_outreg #(.SLOTS(SLOTS)) u_outreg (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld_in  (in_valid),
      .votes   (votes),
      .vld_out (out_valid),
      .early_q (early),
      .late_q  (late),
      .wt_q    (weight)
   );

   // R1
   valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R1
   valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

endmodule

// File: tb/tb_pam4_el_detector.sv
module tb_pam4_el_detector;

   localparam int CLK_PERIOD = 10;
   localparam int NS = 32;
   localparam int SL = NS - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [1:0]        mode = 2'd0;
   logic              sum_sel = 1'b0;
   logic [2*NS-1:0]   sym_in = '0;
   logic [3*SL-1:0]   edge_in = '0;
   logic              out_valid;
   logic [SL-1:0]     early, late;
   logic [2*SL-1:0]   weight;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic            v;
      logic [SL-1:0]   e;
      logic [SL-1:0]   l;
      logic [2*SL-1:0] w;
      string           tag;
   } exp_t;

   exp_t q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   pam4_el_detector #(.N_SYM(NS)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
      .sum_sel(sum_sel), .sym_in(sym_in), .edge_in(edge_in),
      .out_valid(out_valid), .early(early), .late(late), .weight(weight)
   );

   task automatic chk(input string tag, input logic [2*SL-1:0] act,
                      input logic [2*SL-1:0] exp_v);
      checks++;
      if (act !== exp_v) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
      end
   endtask

   function automatic int iabs(input int x);
      return (x < 0) ? -x : x;
   endfunction

   // arithmetic reference: levels -3,-1,+1,+3 and thresholds -2,0,+2
   function automatic void ref_slot(input int m, input bit s, input int a,
                                    input int b, input logic [2:0] smp,
                                    output bit ea, output bit la, output int w);
      int va, vb, mid, net;
      int th[3];
      int v[3];
      bit zc;
      th[0] = -2; th[1] = 0; th[2] = 2;
      va = 2*a - 3;
      vb = 2*b - 3;
      for (int j = 0; j < 3; j++) begin
         bit sa, sb;
         sa = (va > th[j]);
         sb = (vb > th[j]);
         v[j] = (sa == sb) ? 0 : ((smp[j] == sb) ? 1 : -1);
      end
      mid = va + vb;
      zc  = ((va > 0) != (vb > 0));
      net = 0;
      case (m)
         0: if (zc && mid == 0) net = v[1];
         1: if (zc) begin
               if (mid == 0)                  net = v[1];
               else if (iabs(va) > iabs(vb))  net = (v[1] > 0) ? 1 : 0;
               else                           net = (v[1] < 0) ? -1 : 0;
            end
         2: net = v[1];
         default: begin
            if (zc && mid == 0)  net = v[1];
            else if (mid == 4)   net = v[2];
            else if (mid == -4)  net = v[0];
            else if (zc)         net = v[0] + v[1] + v[2];
         end
      endcase
      ea = (net > 0);
      la = (net < 0);
      w  = s ? iabs(net) : ((net != 0) ? 1 : 0);
   endfunction

   task automatic drive(input bit v, input int m, input bit s,
                        input logic [2*NS-1:0] sy, input logic [3*SL-1:0] ed,
                        input string tag);
      exp_t x;
      @(negedge clk);
      in_valid = v;
      mode     = 2'(m);
      sum_sel  = s;
      sym_in   = sy;
      edge_in  = ed;
      x.v = v; x.e = '0; x.l = '0; x.w = '0; x.tag = tag;
      if (v) begin
         for (int k = 0; k < SL; k++) begin
            bit ea, la;
            int w;
            ref_slot(m, s, int'(sy[2*k +: 2]), int'(sy[2*k+2 +: 2]),
                     ed[3*k +: 3], ea, la, w);
            x.e[k] = ea;
            x.l[k] = la;
            x.w[2*k +: 2] = 2'(w);
         end
      end
      q.push_back(x);
   endtask

   // monitor: one item per cycle, sampled after the capturing edge
   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         exp_t x;
         logic [SL-1:0] wnz;
         x = q.pop_front();
         chk("R1 out_valid", 62'(out_valid), 62'(x.v));
         chk({x.tag, " early"},  62'(early),  62'(x.e));
         chk({x.tag, " late"},   62'(late),   62'(x.l));
         chk({x.tag, " weight"}, weight,      x.w);
         for (int k = 0; k < SL; k++) wnz[k] = (weight[2*k +: 2] != 2'd0);
         chk("R10 both flags", 62'(early & late), '0);
         chk("R10 weight vs flags", 62'(wnz), 62'(early | late));
      end
   end

   function automatic logic [2*NS-1:0] rnd_sym();
      logic [2*NS-1:0] r;
      for (int i = 0; i < NS; i++) r[2*i +: 2] = 2'($urandom_range(3));
      return r;
   endfunction

   function automatic logic [3*SL-1:0] rnd_edge();
      logic [3*SL-1:0] r;
      for (int i = 0; i < SL; i++) r[3*i +: 3] = 3'($urandom_range(7));
      return r;
   endfunction

   function automatic logic [2*NS-1:0] alt_sym(input logic [1:0] p,
                                               input logic [1:0] r);
      logic [2*NS-1:0] s;
      for (int i = 0; i < NS; i++) s[2*i +: 2] = (i % 2 == 0) ? p : r;
      return s;
   endfunction

   function automatic logic [3*SL-1:0] fill_edge(input logic [2:0] e);
      logic [3*SL-1:0] r;
      for (int i = 0; i < SL; i++) r[3*i +: 3] = e;
      return r;
   endfunction

   initial begin
      string tags[4];
      tags[0] = "R5"; tags[1] = "R6"; tags[2] = "R7"; tags[3] = "R8/R9";
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk("R1 reset valid",  62'(out_valid), '0);
      chk("R1 reset early",  62'(early), '0);
      chk("R1 reset late",   62'(late), '0);
      chk("R1 reset weight", weight, '0);
      @(negedge clk);
      rst_n = 1'b1;

      // R4: alternating 00/11 with edges siding with later / earlier symbol
      // even slots go 00->11, odd slots 11->00; zero bit = later side gives all early
      begin
         logic [3*SL-1:0] ed;
         for (int i = 0; i < SL; i++) ed[3*i +: 3] = (i % 2 == 0) ? 3'b010 : 3'b000;
         drive(1, 0, 0, alt_sym(2'b00, 2'b11), ed, "R4 later-side");
         for (int i = 0; i < SL; i++) ed[3*i +: 3] = (i % 2 == 0) ? 3'b000 : 3'b010;
         drive(1, 0, 0, alt_sym(2'b00, 2'b11), ed, "R4 earlier-side");
      end
      // R6: -3/+1 alternation, all-positive and all-negative zero samples
      drive(1, 1, 0, alt_sym(2'b00, 2'b10), fill_edge(3'b010), "R6 pos");
      drive(1, 1, 0, alt_sym(2'b00, 2'b10), fill_edge(3'b000), "R6 neg");
      drive(1, 1, 0, alt_sym(2'b01, 2'b11), fill_edge(3'b010), "R6 inner");
      // R7: open mode on asymmetric crossings
      drive(1, 2, 0, alt_sym(2'b00, 2'b10), fill_edge(3'b010), "R7 asym");
      // R8: high and low symmetric pairs
      drive(1, 3, 0, alt_sym(2'b10, 2'b11), fill_edge(3'b100), "R8 high");
      drive(1, 3, 0, alt_sym(2'b00, 2'b01), fill_edge(3'b000), "R8 low");
      // R9: asymmetric crossings, thermometer-consistent samples
      drive(1, 3, 0, alt_sym(2'b00, 2'b10), fill_edge(3'b011), "R9 majority");
      drive(1, 3, 1, alt_sym(2'b00, 2'b10), fill_edge(3'b011), "R9 sum");
      drive(1, 3, 1, alt_sym(2'b00, 2'b10), fill_edge(3'b001), "R9 sum tie");
      // R3: constant level, every mode
      for (int m = 0; m < 4; m++)
         drive(1, m, 1, alt_sym(2'(m), 2'(m)), rnd_edge(), "R3 same level");
      // R2: invalid words with busy data
      drive(0, 2, 1, rnd_sym(), rnd_edge(), "R2 idle");
      drive(0, 3, 1, rnd_sym(), rnd_edge(), "R2 idle");
      // random words in every mode and combining choice
      for (int m = 0; m < 4; m++)
         for (int s = 0; s < 2; s++)
            for (int n = 0; n < 25; n++) begin
               drive(1, m, s[0], rnd_sym(), rnd_edge(), tags[m]);
               if (n % 7 == 3) drive(0, m, s[0], rnd_sym(), rnd_edge(), "R2 gap");
            end
      drive(0, 0, 0, '0, '0, "R2 tail");
      repeat (3) @(posedge clk);
      #2;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      errors++;
      checks++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule